// File: doc/BRIEF.md
# Cyclic Wake Input Sampler

This block watches a slow external wake line without powering its bias network all the time. A period timer, built on a prescaled clock, opens a short powered window at a fixed interval. The window length is fixed. While the window is open the block drives a bias-enable output so that the line settles to a valid level. After a settling delay inside the window, the block captures the synchronised pin level.

The captured level sits in a hold flop until the next window. The hold flop also tells the outside bias network which way to pull the line, so a HIGH stays HIGH and a LOW stays LOW until a sample disagrees. When a sample differs from the held level, the held level takes the new value. If the direction of that change is enabled, the block emits a wake pulse that lasts one clock.

The interval can be short or long, chosen by one select input. All timings are counted in prescaler ticks and set by parameters. With the defaults and a 1 MHz clock, the figures are: one 16 µs tick, a 16 ms or 32 ms interval, a 384 µs window, and capture at 256 µs into the window.

Top module: `wake_cyclic_sampler`

## Requirements
- R1: The interval from one rising edge of `bias_en` to the next is PERIOD_SHORT×PRESCALE clock cycles when `period_sel`=0 and PERIOD_LONG×PRESCALE cycles when `period_sel`=1.
- R2: In each interval, `bias_en` is high for exactly WINDOW×PRESCALE consecutive clock cycles, starting at the rising edge.
- R3: The pin is captured once per interval. A changed sample becomes visible on `held_level` SETUP×PRESCALE−1 cycles after the first cycle in which `bias_en` is high, which lies inside the window.
- R4: `held_level` changes only at a capture. Pin activity between captures has no effect on `held_level` or `wake_pulse`.
- R5: `wake_pulse` is high for one cycle, in the same cycle that `held_level` takes a new value. It fires only if the change direction is enabled: `edge_mode` bit 0 enables low-to-high changes and bit 1 enables high-to-low changes.
- R6: While `en`=0, `bias_en` is low, `held_level` is frozen, `wake_pulse` stays low, and the timer is cleared. After `en` returns high, a new window starts on the next clock.
- R7: Synchronous reset clears `bias_en`, `held_level` and `wake_pulse` and restarts the timer. The first window starts on the first clock after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Sampler enable |
| period_sel | input | 1 | 0 selects the short interval, 1 the long interval |
| edge_mode | input | 2 | Bit 0 enables pulses on rising changes, bit 1 on falling changes |
| wake_pin | input | 1 | Raw wake line level (asynchronous) |
| bias_en | output | 1 | Bias/supply enable for the sampling window |
| held_level | output | 1 | Held pin level, also used to choose the bias direction |
| wake_pulse | output | 1 | One-cycle wake event |

## Verification
The assertions check on every cycle the following properties:
- the held level moves only on a capture strobe;
- a capture strobe always falls inside an open window;
- a wake pulse lasts one cycle and always comes with a change of the held level;
- a disabled or reset block keeps the bias off and the held level still.

Other behaviour needs the bench's scenarios to show it:
- the cycle counts of interval, window and capture offset under both period selections;
- the direction filtering for every `edge_mode` value;
- rejection of a pin glitch placed between captures;
- the restart of the timer after re-enable and after reset.

// File: rtl/wake_pkg.sv
package wake_pkg;

  // Direction filter for wake events: bit 1 falling, bit 0 rising.
  typedef struct packed {
    logic fall_en;
    logic rise_en;
  } wake_edge_cfg_t;

  // Width of a counter that must hold values 0..n-1.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/wake_prescaler.sv
module wake_prescaler #(
  parameter int unsigned DIV = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  import wake_pkg::*;

  localparam int unsigned CW = cnt_width(DIV);

  generate
    if (DIV == 1) begin : g_nodiv
      assign tick = run;
    end else begin : g_div
      logic [CW-1:0] cnt_q;
      logic          at_end;

      assign at_end = (cnt_q == CW'(DIV - 1));
      assign tick   = run && at_end;

      always_ff @(posedge clk) begin
        if (rst || !run) begin
          cnt_q <= '0;
        end else if (at_end) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/wake_cycle_timer.sv
module wake_cycle_timer #(
  parameter int unsigned PERIOD_SHORT = 1000,
  parameter int unsigned PERIOD_LONG  = 2000,
  parameter int unsigned WINDOW       = 24,
  parameter int unsigned SETUP        = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  input  logic long_sel,
  output logic bias_q,
  output logic sample_stb
);
  import wake_pkg::*;

  localparam int unsigned PMAX = (PERIOD_LONG > PERIOD_SHORT) ? PERIOD_LONG : PERIOD_SHORT;
  localparam int unsigned PHW  = cnt_width(PMAX);

  logic [PHW-1:0] ph_q;
  logic [PHW-1:0] ph_last;
  logic           in_window;

  assign ph_last    = long_sel ? PHW'(PERIOD_LONG - 1) : PHW'(PERIOD_SHORT - 1);
  assign in_window  = (ph_q < PHW'(WINDOW));
  // Capture on the tick that moves the phase onto SETUP.
  assign sample_stb = run && tick && (ph_q == PHW'(SETUP - 1));

  // Phase counter in ticks; wraps at the selected interval.
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      ph_q <= '0;
    end else if (tick) begin
      if (ph_q >= ph_last) begin
        ph_q <= '0;
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end

  // Registered bias window.
  always_ff @(posedge clk) begin
    if (rst) begin
      bias_q <= 1'b0;
    end else begin
      bias_q <= run && in_window;
    end
  end

  // R6
  bias_off_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> !bias_q);

  // R3
  sample_in_window_chk: assert property (@(posedge clk) disable iff (rst)
    (sample_stb && $past(run)) |-> bias_q);

endmodule

// File: rtl/wake_pin_sync.sv
module wake_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_raw,
  output logic pin_s
);

  logic [STAGES-1:0] sr_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sr_q[0] <= 1'b0;
          else     sr_q[0] <= pin_raw;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sr_q[i] <= 1'b0;
          else     sr_q[i] <= sr_q[i-1];
        end
      end
    end
  endgenerate

  assign pin_s = sr_q[STAGES-1];

endmodule

// File: rtl/wake_edge_latch.sv
module wake_edge_latch (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sample_stb,
  input  logic                    pin_s,
  input  wake_pkg::wake_edge_cfg_t cfg,
  output logic                    held_q,
  output logic                    pulse_q
);

  logic changed;
  assign changed = sample_stb && (pin_s != held_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (changed) begin
        held_q  <= pin_s;
        pulse_q <= pin_s ? cfg.rise_en : cfg.fall_en;
      end
    end
  end

  // R4
  held_only_on_sample_chk: assert property (@(posedge clk) disable iff (rst)
    !sample_stb |=> $stable(held_q));

  // R5
  pulse_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_q |=> !pulse_q);

  // R5
  pulse_with_change_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_q |-> (held_q != $past(held_q)));

endmodule

// File: rtl/wake_cyclic_sampler.sv
module wake_cyclic_sampler #(
  parameter int unsigned PRESCALE     = 16,
  parameter int unsigned PERIOD_SHORT = 1000,
  parameter int unsigned PERIOD_LONG  = 2000,
  parameter int unsigned WINDOW       = 24,
  parameter int unsigned SETUP        = 16,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       period_sel,
  input  logic [1:0] edge_mode,
  input  logic       wake_pin,
  output logic       bias_en,
  output logic       held_level,
  output logic       wake_pulse
);
  import wake_pkg::*;

  logic           tick;
  logic           sample_stb;
  logic           pin_s;
  wake_edge_cfg_t cfg;

  assign cfg = wake_edge_cfg_t'(edge_mode);

  wake_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .run  (en),
    .tick (tick)
  );

  wake_cycle_timer #(
    .PERIOD_SHORT (PERIOD_SHORT),
    .PERIOD_LONG  (PERIOD_LONG),
    .WINDOW       (WINDOW),
    .SETUP        (SETUP)
  ) u_timer (
    .clk        (clk),
    .rst        (rst),
    .run        (en),
    .tick       (tick),
    .long_sel   (period_sel),
    .bias_q     (bias_en),
    .sample_stb (sample_stb)
  );

  wake_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .pin_raw (wake_pin),
    .pin_s   (pin_s)
  );

  wake_edge_latch u_latch (
    .clk        (clk),
    .rst        (rst),
    .sample_stb (sample_stb),
    .pin_s      (pin_s),
    .cfg        (cfg),
    .held_q     (held_level),
    .pulse_q    (wake_pulse)
  );

  // R6
  held_frozen_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(held_level) && !wake_pulse));

  // R7
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!bias_en && !held_level && !wake_pulse));

endmodule

// File: tb/tb_wake_cyclic_sampler.sv
module tb_wake_cyclic_sampler;

  localparam int CLK_PERIOD = 10;
  localparam int PRE   = 2;
  localparam int PSH   = 20;
  localparam int PLG   = 40;
  localparam int WIN   = 6;
  localparam int SET   = 4;
  localparam int CHG_OFF = SET * PRE - 1;

  logic clk = 1'b0;
  logic rst, en, period_sel, wake_pin;
  logic [1:0] edge_mode;
  logic bias_en, held_level, wake_pulse;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wake_cyclic_sampler #(
    .PRESCALE(PRE), .PERIOD_SHORT(PSH), .PERIOD_LONG(PLG),
    .WINDOW(WIN), .SETUP(SET), .SYNC_STAGES(2)
  ) dut (
    .clk(clk), .rst(rst), .en(en), .period_sel(period_sel),
    .edge_mode(edge_mode), .wake_pin(wake_pin),
    .bias_en(bias_en), .held_level(held_level), .wake_pulse(wake_pulse)
  );

  // {period_sel, edge_mode[1:0], pin, exp_held, exp_pulse}
  localparam logic [5:0] VEC [0:7] = '{
    6'b0_01_1_1_1,
    6'b0_01_1_1_0,
    6'b1_01_0_0_0,
    6'b1_10_1_1_0,
    6'b0_10_0_0_1,
    6'b0_11_1_1_1,
    6'b1_11_0_0_1,
    6'b0_00_1_1_0
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Called at the negedge just after a bias rise; returns at the next rise.
  task automatic measure(output int per, output int hi, output int chg,
                         output int pulses);
    logic prev_bias, prev_held;
    int c;
    per = -1; hi = 1; chg = -1; pulses = 0; c = 0;
    prev_bias = bias_en; prev_held = held_level;
    while (c < 1000) begin
      @(negedge clk);
      c++;
      if (bias_en && !prev_bias) begin
        per = c;
        break;
      end
      if (bias_en) hi++;
      if (held_level != prev_held) chg = c;
      if (wake_pulse) pulses++;
      prev_bias = bias_en;
      prev_held = held_level;
    end
  endtask

  task automatic run_period(input logic sel, input logic [1:0] mode,
                            input logic pin, input logic exp_h, input bit exp_p);
    int per, hi, chg, pulses, exp_per;
    logic start_held;
    start_held = held_level;
    period_sel = sel; edge_mode = mode; wake_pin = pin;
    measure(per, hi, chg, pulses);
    exp_per = (sel ? PLG : PSH) * PRE;
    check(per == exp_per, "R1", "interval cycles", per, exp_per);
    check(hi == WIN * PRE, "R2", "bias high cycles", hi, WIN * PRE);
    check(held_level == exp_h, "R4", "held level", held_level, exp_h);
    check(pulses == int'(exp_p), "R5", "wake pulses", pulses, int'(exp_p));
    if (exp_h != start_held)
      check(chg == CHG_OFF, "R3", "capture offset", chg, CHG_OFF);
    else
      check(chg == -1, "R4", "no held change", chg, -1);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    rst = 1'b1; en = 1'b1; period_sel = 1'b0; edge_mode = 2'b01; wake_pin = 1'b0;
    @(negedge clk); @(negedge clk);
    // R7 reset state
    check(!bias_en && !held_level && !wake_pulse, "R7", "reset outputs",
          {bias_en, held_level, wake_pulse}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(bias_en == 1'b1, "R7", "first window after reset", bias_en, 1);

    // Vector table walk (R1..R5)
    for (int i = 0; i < 8; i++) begin
      run_period(VEC[i][5], VEC[i][4:3], VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // R4: glitch between captures is ignored (held is 1, short interval)
    begin
      int c, errs;
      logic nb;
      c = 0; errs = 0; nb = 1'b0;
      period_sel = 1'b0; edge_mode = 2'b11; wake_pin = 1'b1;
      while (c < 200) begin
        @(negedge clk);
        c++;
        if (c == 12) wake_pin = 1'b0;
        if (c == 30) wake_pin = 1'b1;
        if (held_level !== 1'b1 || wake_pulse !== 1'b0) errs++;
        if (bias_en && c > WIN * PRE) begin nb = 1'b1; break; end
      end
      check(errs == 0 && nb, "R4", "glitch between captures", errs, 0);
      run_period(1'b0, 2'b11, 1'b1, 1'b1, 1'b0);
    end

    // R6: disable freezes everything
    begin
      int errs;
      errs = 0;
      en = 1'b0; wake_pin = 1'b0; edge_mode = 2'b11;
      for (int k = 0; k < 100; k++) begin
        @(negedge clk);
        if (bias_en !== 1'b0 || held_level !== 1'b1 || wake_pulse !== 1'b0) errs++;
      end
      check(errs == 0, "R6", "disabled outputs", errs, 0);
      en = 1'b1;
      @(negedge clk);
      check(bias_en == 1'b1, "R6", "window restarts on enable", bias_en, 1);
      run_period(1'b0, 2'b11, 1'b0, 1'b0, 1'b1);
    end

    // R7: reset in mid-run
    run_period(1'b0, 2'b01, 1'b1, 1'b1, 1'b1);
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(!bias_en && !held_level && !wake_pulse, "R7", "mid-run reset outputs",
          {bias_en, held_level, wake_pulse}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(bias_en == 1'b1, "R7", "window after mid-run reset", bias_en, 1);
    run_period(1'b0, 2'b01, 1'b1, 1'b1, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule